// File: doc/BRIEF.md
# Synchronous Byte-Lane Write Static Memory

A clocked single-port static memory holding words of four 9-bit lanes (36 bits total). Every rising clock edge samples the controls and classifies the cycle as a read, a masked write, an abort, a deselect or a sleep cycle. Sleep outranks every other control. Select outranks the write controls. With select active, the write enable chooses between a read and a write. During a write, each lane whose own active-low enable is low takes its slice of the input word.

The bidirectional data bus appears as three signals. A write-data input carries data in. A read-data output carries data out. A drive flag tells the pad logic when the bus must be driven. Read data is registered: a read taken at edge n drives the bus from just after edge n until edge n+1. The active-low output enable acts asynchronously on that registered data. Whenever the flag is low, the read-data output is held at zero. The depth is a parameter, so a simulation can use a small array.

Top module: `sram_bytewr`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `drive_o` is 0 and `rdata_o` is 0 until the first read.
- R2: A read cycle (`sleep_i`=0, `sel_ni`=0, `we_ni`=1) at edge n makes `rdata_o` equal the stored word at `addr_i` and `drive_o`=1 from edge n to edge n+1, provided `oe_ni`=0.
- R3: A write cycle (`sleep_i`=0, `sel_ni`=0, `we_ni`=0) writes the data into every lane k whose `lane_we_ni[k]` is 0. Lane k occupies word bits 9k to 9k+8.
- R4: In a write cycle, each lane whose `lane_we_ni` bit is 1 keeps its previous contents.
- R5: A write cycle with `lane_we_ni`=4'b1111 is an abort: no memory bit changes.
- R6: With `sel_ni`=1 (and `sleep_i`=0) no read or write happens, and `drive_o` is 0 in the following cycle.
- R7: With `sleep_i`=1 no read or write happens, whatever the other controls are, and `drive_o` is 0 in the following cycle.
- R8: `oe_ni`=1 forces `drive_o` to 0 without waiting for a clock edge. Whenever `drive_o` is 0, `rdata_o` is 0.
- R9: Memory contents survive sleep and deselect cycles. The first read afterwards returns the data written before them.
- R10: Any write cycle, including an abort, leaves `drive_o` at 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all controls sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset of the output stage |
| sleep_i | input | 1 | Sleep request, overrides all other controls |
| sel_ni | input | 1 | Active-low chip select |
| we_ni | input | 1 | Active-low write enable (1 = read) |
| lane_we_ni | input | 4 | Active-low per-lane write enables, bit k for lane k |
| oe_ni | input | 1 | Active-low asynchronous output enable |
| addr_i | input | $clog2(DEPTH) | Word address |
| wdata_i | input | 36 | Write data, captured at the write edge |
| rdata_o | output | 36 | Registered read data, zero when not driven |
| drive_o | output | 1 | High when the data bus must be driven |

## Verification
On every cycle, the assertions check these properties:
- Sleep, deselect and abort never produce a write strobe.
- Any write strobe matches exactly the lanes whose enables are low.
- The bus is driven only in the cycle after a sampled read.
- The read-data output is zero whenever the bus is not driven.

Only the bench's scenarios can show that data actually lands in the right lanes and survives sleep and deselect. They also show that reads return the stored words. The bench sweeps every address and every lane mask against a reference array.

// File: rtl/sram_bytewr_pkg.sv
package sram_bytewr_pkg;
  typedef enum logic [2:0] {
    CYC_SLEEP,
    CYC_DESEL,
    CYC_READ,
    CYC_WRITE,
    CYC_ABORT
  } cyc_e;
endpackage

// File: rtl/sram_bytewr_dec.sv
module sram_bytewr_dec
  import sram_bytewr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] lane_we_ni,
  output logic             rd_en_o,
  output logic [LANES-1:0] lane_wr_o
);
  cyc_e cyc;

  // priority: sleep > select > write enable > lane enables
  always_comb begin
    if (sleep_i)            cyc = CYC_SLEEP;
    else if (sel_ni)        cyc = CYC_DESEL;
    else if (we_ni)         cyc = CYC_READ;
    else if (&lane_we_ni)   cyc = CYC_ABORT;
    else                    cyc = CYC_WRITE;
  end

  assign rd_en_o   = (cyc == CYC_READ);
  assign lane_wr_o = (cyc == CYC_WRITE) ? ~lane_we_ni : '0;

  p_sleep_no_access_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (lane_wr_o == '0 && !rd_en_o));
  p_desel_no_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |-> (lane_wr_o == '0 && !rd_en_o));
  p_abort_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&lane_we_ni) |-> (lane_wr_o == '0));
  p_lane_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_wr_o != '0) |-> (lane_wr_o == ~lane_we_ni && !we_ni));
endmodule

// File: rtl/sram_bytewr_mem.sv
module sram_bytewr_mem #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic [LANES-1:0] lane_wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     word_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];

    always_ff @(posedge clk_i) begin
      if (lane_wr_i[g]) arr[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end

    assign word_o[g*LANE_W +: LANE_W] = arr[addr_i];
  end
endmodule

// File: rtl/sram_bytewr_out.sv
module sram_bytewr_out #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rd_en_i,
  input  logic [W-1:0] word_i,
  input  logic         oe_ni,
  output logic [W-1:0] rdata_o,
  output logic         drive_o
);
  logic [W-1:0] rd_q;
  logic         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= rd_en_i;
      if (rd_en_i) rd_q <= word_i;
    end
  end

  // output enable gates the registered word asynchronously
  assign drive_o = vld_q & ~oe_ni;
  assign rdata_o = drive_o ? rd_q : '0;

  p_idle_bus_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0));
  p_drive_after_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> $past(rd_en_i));
endmodule

// File: rtl/sram_bytewr.sv
module sram_bytewr #(
  parameter int DEPTH  = 256,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] lane_we_ni,
  input  logic             oe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     rdata_o,
  output logic             drive_o
);
  logic             rd_en;
  logic [LANES-1:0] lane_wr;
  logic [W-1:0]     word;

  sram_bytewr_dec #(.LANES(LANES)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sleep_i    (sleep_i),
    .sel_ni     (sel_ni),
    .we_ni      (we_ni),
    .lane_we_ni (lane_we_ni),
    .rd_en_o    (rd_en),
    .lane_wr_o  (lane_wr)
  );

  sram_bytewr_mem #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i     (clk_i),
    .lane_wr_i (lane_wr),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .word_o    (word)
  );

  sram_bytewr_out #(.W(W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en),
    .word_i  (word),
    .oe_ni   (oe_ni),
    .rdata_o (rdata_o),
    .drive_o (drive_o)
  );

  p_no_drive_after_sleep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sleep_i) |-> !drive_o);
  p_no_drive_after_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!sleep_i && !sel_ni && !we_ni) |-> !drive_o);
endmodule

// File: tb/sram_bytewr_tb.sv
module sram_bytewr_tb;
  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_i = 1'b0, sel_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [3:0]    lane_we_ni = 4'hF;
  logic [AW-1:0] addr_i = '0;
  logic [35:0]   wdata_i = '0;
  logic [35:0]   rdata_o;
  logic          drive_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [35:0] model_q [DEPTH];

  always #10 clk = ~clk;

  sram_bytewr #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i), .sel_ni(sel_ni),
    .we_ni(we_ni), .lane_we_ni(lane_we_ni), .oe_ni(oe_ni), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .drive_o(drive_o)
  );

  function automatic logic [35:0] pat(input int a, input int s);
    logic [35:0] v;
    for (int k = 0; k < 4; k++) v[k*9 +: 9] = 9'((a * 37 + s * 101 + k * 59 + 3) % 512);
    return v;
  endfunction

  task automatic chk(input string rq, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // one clocked cycle; checks drive_o and rdata_o in the cycle after the edge
  task automatic cyc(input logic sl, input logic se, input logic we, input logic [3:0] ln,
                     input logic oe, input int a, input logic [35:0] d, input string rq);
    logic        is_rd, exp_drv;
    logic [35:0] exp_dat;
    @(negedge clk);
    sleep_i = sl; sel_ni = se; we_ni = we; lane_we_ni = ln; oe_ni = oe;
    addr_i = AW'(a); wdata_i = d;
    @(posedge clk);
    is_rd   = !sl && !se && we;
    exp_drv = is_rd && !oe;
    exp_dat = exp_drv ? model_q[a] : '0;
    if (!sl && !se && !we)
      for (int k = 0; k < 4; k++) if (!ln[k]) model_q[a][k*9 +: 9] = d[k*9 +: 9];
    #5;
    chk({rq, " drive"}, {35'd0, drive_o}, {35'd0, exp_drv});
    chk({rq, " data"}, rdata_o, exp_dat);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    #3;
    chk("R1 reset drive", {35'd0, drive_o}, 36'd0);
    chk("R1 reset data", rdata_o, 36'd0);

    // R3/R10: fill every word with all lanes enabled
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, 4'h0, 0, a, pat(a, 0), "R10 full write");
    // R2: read back every word
    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 1, 4'hF, 0, a, '0, "R2 read");

    // R3/R4/R5: every lane mask on every address, read back after each
    for (int m = 0; m < 16; m++)
      for (int a = 0; a < DEPTH; a++) begin
        cyc(0, 0, 0, 4'(m), 0, a, pat(a, m + 1), (m == 15) ? "R5 abort" : "R4 lane write");
        cyc(0, 0, 1, 4'hF, 0, a, '0, (m == 15) ? "R5 abort readback" : "R3 lane readback");
      end

    // R6: deselect with write controls active must not write
    cyc(0, 1, 0, 4'h0, 0, 3, ~model_q[3], "R6 deselect write");
    cyc(0, 1, 1, 4'hF, 0, 3, '0, "R6 deselect read");
    cyc(0, 0, 1, 4'hF, 0, 3, '0, "R6 after deselect");

    // R7/R9: sleep blocks writes and reads, contents kept
    cyc(0, 0, 1, 4'hF, 0, 5, '0, "R2 read before sleep");
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 4'h0, 0, 5, ~model_q[5], "R7 sleep write");
    cyc(1, 0, 1, 4'hF, 0, 5, '0, "R7 sleep read");
    cyc(1, 1, 1, 4'hF, 0, 5, '0, "R7 sleep deselect");
    cyc(0, 0, 1, 4'hF, 0, 5, '0, "R9 first read after sleep");
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 4'hF, 0, 6, '0, "R9 idle deselect");
    cyc(0, 0, 1, 4'hF, 0, 6, '0, "R9 read after deselect");

    // R8: output enable acts without a clock edge
    cyc(0, 0, 1, 4'hF, 1, 7, '0, "R8 read oe high");
    @(negedge clk);
    oe_ni = 1'b0; sleep_i = 1'b1;
    #2;
    chk("R8 oe low drive", {35'd0, drive_o}, 36'd1);
    chk("R8 oe low data", rdata_o, model_q[7]);
    oe_ni = 1'b1;
    #2;
    chk("R8 oe high drive", {35'd0, drive_o}, 36'd0);
    chk("R8 oe high data", rdata_o, 36'd0);

    // R10: abort write also stops driving
    cyc(0, 0, 1, 4'hF, 0, 8, '0, "R2 read");
    cyc(0, 0, 0, 4'hF, 0, 8, '1, "R10 abort no drive");
    cyc(0, 0, 1, 4'hF, 0, 8, '0, "R5 abort keeps word");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule